// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds three outgoing CAN frames in three mailboxes and decides which one is handed next to a frame-level transmitter. Software, or a bus front end, offers a frame on the submit port. The block reports which mailbox will take it, or that all of them are occupied. Each mailbox stores an identifier word, a 4-bit length code and two 32-bit data words. It keeps a mailbox-empty, a finished and a finished-without-error flag. Together these three flags give the mailbox's state.

The transmitter is a model that stands in for bit-level serialization, bus arbitration and CRC. It signals that it can accept a frame. The scheduler then presents one pending mailbox with a one-cycle start pulse and waits for one of three results: sent, arbitration lost or error. Two ordering policies are selectable. In the first, the lowest arbitration key wins. In the second, the oldest request wins. Lost or failed attempts are retried unless retransmission is disabled. Each mailbox can be aborted by its own stop input. A mailbox-empty interrupt, finished flags cleared by writing one and per-mailbox time-stamp enables complete the block.

Top module: `can_txmb_sched`

## Requirements
- R1: A submitted frame goes into the lowest-numbered empty mailbox, and `sub_slot` names that mailbox. When no mailbox is empty, `sub_none` is 1 and the submission changes no mailbox.
- R2: Identifier word layout: bit 0 is the transmit request, bit 1 the remote flag and bit 2 the extended flag. A standard identifier occupies bits 31:21. An extended identifier occupies bits 31:3. With `cfg_fifo_order`=0, the pending mailbox with the lowest key is launched first. The key is compared in this order: bits 31:21, then bit 2, then bits 20:3 (extended frames only), then bit 1. On equal keys the lower mailbox index wins.
- R3: With `cfg_fifo_order`=1, the pending mailbox that was submitted earliest is launched first, whatever its identifier.
- R4: Per-mailbox status is encoded by the bits {empty, finished, no-error}. Pending is 0,0,0. Success is 1,1,1. Failed is 1,1,0. After reset every mailbox reads 1,0,0.
- R5: When no attempt is in flight, `tx_ready` is 1 and a mailbox is pending, `tx_start` pulses high for one cycle. While the attempt is in flight, `tx_slot`, `tx_id`, `tx_dlc`, `tx_data0` and `tx_data1` present the chosen mailbox: data byte k sits in bits 8k+7:8k of `tx_data0` for k<4, and byte k+4 sits in the same bits of `tx_data1`. Only one attempt is in flight at a time.
- R6: `tx_done` during an attempt finishes that mailbox with status success.
- R7: With `cfg_no_retx`=0, `tx_lost` or `tx_err` leaves the mailbox pending, and it is launched again.
- R8: With `cfg_no_retx`=1, `tx_lost` or `tx_err` finishes the mailbox with status failed, and it is not launched again.
- R9: A `stop_req` bit aborts a pending mailbox that is not in flight: the mailbox becomes failed at once. A stop during flight turns a following lost or error result into failed without retry, while `tx_done` still gives success. A stop on a mailbox that is not pending has no effect.
- R10: Writing 1 to a `clr_fin` bit clears that mailbox's finished and no-error flags.
- R11: `irq` is 1 exactly when `irq_en` is 1 and at least one finished flag is set.
- R12: Each `mb_tse` bit follows `cfg_ttm` one cycle later, for all three mailboxes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_valid | input | 1 | Submit a frame this cycle |
| sub_id | input | 32 | Identifier word of the submitted frame |
| sub_dlc | input | 4 | Length code |
| sub_data0 | input | 32 | Data bytes 0..3, byte 0 lowest |
| sub_data1 | input | 32 | Data bytes 4..7, byte 4 lowest |
| sub_slot | output | 2 | Mailbox that a submission would take |
| sub_none | output | 1 | No mailbox is empty |
| cfg_fifo_order | input | 1 | 1: oldest request first, 0: lowest key first |
| cfg_no_retx | input | 1 | Disable retransmission |
| cfg_ttm | input | 1 | Time-triggered mode |
| irq_en | input | 1 | Mailbox-empty interrupt enable |
| stop_req | input | 3 | Per-mailbox abort |
| clr_fin | input | 3 | Per-mailbox write-one clear of finished flags |
| tx_ready | input | 1 | Transmitter can accept a frame |
| tx_start | output | 1 | One-cycle launch pulse |
| tx_slot | output | 2 | Mailbox in flight |
| tx_id | output | 32 | Identifier word in flight |
| tx_dlc | output | 4 | Length code in flight |
| tx_data0 | output | 32 | Data bytes 0..3 in flight |
| tx_data1 | output | 32 | Data bytes 4..7 in flight |
| tx_done | input | 1 | Attempt sent successfully |
| tx_lost | input | 1 | Attempt lost arbitration |
| tx_err | input | 1 | Attempt hit a bus error |
| mb_empty | output | 3 | Mailbox-empty flags |
| mb_fin | output | 3 | Finished flags |
| mb_ok | output | 3 | Finished-without-error flags |
| mb_tse | output | 3 | Time-stamp enables |
| irq | output | 1 | Mailbox-empty interrupt |

## Verification
On every cycle the assertions check several invariants. No mailbox shows finished without empty, or no-error without finished. A launch pulse lasts one cycle and always names a mailbox that holds a frame. An accepted submission occupies the mailbox it was offered. The interrupt stays low while disabled. Only the bench scenarios can show the rest: the launch order under both policies with key ties, mixed formats and remote frames, the retry and no-retry outcomes, and the three kinds of stop. These depend on sequences of submissions and transmitter results.

// File: rtl/can_txmb_pkg.sv
// Shared types and the arbitration key used by the mailbox scheduler.
package can_txmb_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned DLC_W  = 4;
    localparam int unsigned KEY_W  = 31;

    typedef struct packed {
        logic [WORD_W-1:0] id;
        logic [DLC_W-1:0]  dlc;
        logic [WORD_W-1:0] d0;
        logic [WORD_W-1:0] d1;
    } txmb_frame_t;

    // Key: base id, format flag, extension (extended only), remote flag; lower wins.
    function automatic logic [KEY_W-1:0] arb_key(input logic [WORD_W-1:0] w);
        return {w[31:21], w[2], w[20:3] & {18{w[2]}}, w[1]};
    endfunction

endpackage

// File: rtl/txmb_lowest.sv
// Finds the lowest set bit of a mask.
// Assumes N fits in IW bits; idx is 0 when the mask is empty.
module txmb_lowest #(
    parameter int unsigned N  = 3,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          none
);
    // Scan from the top so the lowest set bit is assigned last.
    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx  = IW'(i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/txmb_pick.sv
// Chooses the next mailbox among candidates by key or by age.
// Assumes the age matrix is consistent; older[i*N+j] means i was submitted before j.
module txmb_pick #(
    parameter int unsigned N  = 3,
    parameter int unsigned IW = 2,
    parameter int unsigned KW = 31
) (
    input  logic [N-1:0]    cand,
    input  logic [N*KW-1:0] keys,
    input  logic [N*N-1:0]  older,
    input  logic            fifo_mode,
    output logic [IW-1:0]   win,
    output logic            any
);
    logic [N-1:0] beats;
    logic         no_win;

    // A candidate survives if it beats every other candidate.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            beats[i] = cand[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && cand[j]) begin
                    if (fifo_mode) begin
                        if (!older[i*N+j]) beats[i] = 1'b0;
                    end else if ((keys[i*KW +: KW] > keys[j*KW +: KW]) ||
                                 ((keys[i*KW +: KW] == keys[j*KW +: KW]) && (j < i))) begin
                        beats[i] = 1'b0;
                    end
                end
            end
        end
    end

    txmb_lowest #(.N(N), .IW(IW)) u_enc (.mask(beats), .idx(win), .none(no_win));

    assign any = ~no_win;
endmodule

// File: rtl/txmb_slot.sv
// One transmit mailbox: frame storage and its empty/finished/no-error flags.
// Assumes wr only arrives while empty and attempt results only while in flight.
module txmb_slot
    import can_txmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  txmb_frame_t wr_frame,
    input  logic        inflight,
    input  logic        att_ok,
    input  logic        att_bad,
    input  logic        no_retx,
    input  logic        stop,
    input  logic        clr,
    output txmb_frame_t frame,
    output logic        pend,
    output logic        empty,
    output logic        fin,
    output logic        ok
);
    logic stop_pend;

    // Flag and storage update; a finish event overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame     <= '0;
            pend      <= 1'b0;
            empty     <= 1'b1;
            fin       <= 1'b0;
            ok        <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (clr) begin
                fin <= 1'b0;
                ok  <= 1'b0;
            end
            if (wr) begin
                frame       <= wr_frame;
                frame.id[0] <= 1'b1;
                pend        <= 1'b1;
                empty       <= 1'b0;
                fin         <= 1'b0;
                ok          <= 1'b0;
                stop_pend   <= 1'b0;
            end else if (pend && att_ok) begin
                frame.id[0] <= 1'b0;
                pend        <= 1'b0;
                empty       <= 1'b1;
                fin         <= 1'b1;
                ok          <= 1'b1;
                stop_pend   <= 1'b0;
            end else if (pend && ((att_bad && (no_retx || stop_pend || stop)) ||
                                  (stop && !inflight))) begin
                frame.id[0] <= 1'b0;
                pend        <= 1'b0;
                empty       <= 1'b1;
                fin         <= 1'b1;
                ok          <= 1'b0;
                stop_pend   <= 1'b0;
            end else if (pend && stop && inflight) begin
                stop_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/can_txmb_sched.sv
// Three-mailbox CAN transmit scheduler with allocation, ordering and abort.
// Assumes the transmitter answers each start with exactly one result pulse.
module can_txmb_sched
    import can_txmb_pkg::*;
#(
    parameter int unsigned N_MB = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sub_valid,
    input  logic [WORD_W-1:0]       sub_id,
    input  logic [DLC_W-1:0]        sub_dlc,
    input  logic [WORD_W-1:0]       sub_data0,
    input  logic [WORD_W-1:0]       sub_data1,
    output logic [$clog2(N_MB)-1:0] sub_slot,
    output logic                    sub_none,
    input  logic                    cfg_fifo_order,
    input  logic                    cfg_no_retx,
    input  logic                    cfg_ttm,
    input  logic                    irq_en,
    input  logic [N_MB-1:0]         stop_req,
    input  logic [N_MB-1:0]         clr_fin,
    input  logic                    tx_ready,
    output logic                    tx_start,
    output logic [$clog2(N_MB)-1:0] tx_slot,
    output logic [WORD_W-1:0]       tx_id,
    output logic [DLC_W-1:0]        tx_dlc,
    output logic [WORD_W-1:0]       tx_data0,
    output logic [WORD_W-1:0]       tx_data1,
    input  logic                    tx_done,
    input  logic                    tx_lost,
    input  logic                    tx_err,
    output logic [N_MB-1:0]         mb_empty,
    output logic [N_MB-1:0]         mb_fin,
    output logic [N_MB-1:0]         mb_ok,
    output logic [N_MB-1:0]         mb_tse,
    output logic                    irq
);
    localparam int unsigned IDX_W = $clog2(N_MB);

    txmb_frame_t            frames [N_MB];
    txmb_frame_t            in_frame;
    logic [N_MB-1:0]        pend;
    logic [N_MB-1:0]        cand;
    logic [N_MB*KEY_W-1:0]  keys;
    logic [N_MB*N_MB-1:0]   older;
    logic [IDX_W-1:0]       win;
    logic                   any_cand;
    logic                   busy;
    logic [IDX_W-1:0]       cur;
    logic                   launch;
    logic                   start_q;
    logic [N_MB-1:0]        tse_q;

    assign in_frame = '{id: sub_id, dlc: sub_dlc, d0: sub_data0, d1: sub_data1};

    txmb_lowest #(.N(N_MB), .IW(IDX_W)) u_alloc (
        .mask(mb_empty), .idx(sub_slot), .none(sub_none)
    );

    for (genvar g = 0; g < N_MB; g++) begin : g_mb
        logic here;
        assign here = busy && (cur == IDX_W'(g));
        txmb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (sub_valid && !sub_none && (sub_slot == IDX_W'(g))),
            .wr_frame (in_frame),
            .inflight (here),
            .att_ok   (here && tx_done),
            .att_bad  (here && !tx_done && (tx_lost || tx_err)),
            .no_retx  (cfg_no_retx),
            .stop     (stop_req[g]),
            .clr      (clr_fin[g]),
            .frame    (frames[g]),
            .pend     (pend[g]),
            .empty    (mb_empty[g]),
            .fin      (mb_fin[g]),
            .ok       (mb_ok[g])
        );
        assign keys[g*KEY_W +: KEY_W] = arb_key(frames[g].id);
    end

    // A mailbox being stopped this cycle is not eligible for launch.
    assign cand = pend & ~stop_req;

    txmb_pick #(.N(N_MB), .IW(IDX_W), .KW(KEY_W)) u_pick (
        .cand(cand), .keys(keys), .older(older), .fifo_mode(cfg_fifo_order),
        .win(win), .any(any_cand)
    );

    assign launch = !busy && tx_ready && any_cand;

    // Attempt tracking: one frame in flight until the transmitter answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur     <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= launch;
            if (launch) begin
                busy <= 1'b1;
                cur  <= win;
            end else if (busy && (tx_done || tx_lost || tx_err)) begin
                busy <= 1'b0;
            end
        end
    end

    // Age matrix: a newly written mailbox becomes younger than all others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N_MB; i++) begin
                if (sub_valid && !sub_none && (sub_slot == IDX_W'(i))) begin
                    for (int j = 0; j < N_MB; j++) begin
                        if (j != i) begin
                            older[i*N_MB+j] <= 1'b0;
                            older[j*N_MB+i] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Time-stamp enables track the time-triggered mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) tse_q <= '0;
        else        tse_q <= {N_MB{cfg_ttm}};
    end

    assign tx_start = start_q;
    assign tx_slot  = cur;
    assign tx_id    = frames[cur].id;
    assign tx_dlc   = frames[cur].dlc;
    assign tx_data0 = frames[cur].d0;
    assign tx_data1 = frames[cur].d1;
    assign mb_tse   = tse_q;
    assign irq      = irq_en && (|mb_fin);
endmodule

// File: rtl/txmb_sva.sv
// Checker for the mailbox scheduler ports; bound to the top below.
module txmb_sva #(
    parameter int unsigned N_MB  = 3,
    parameter int unsigned IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sub_valid,
    input logic             sub_none,
    input logic [IDX_W-1:0] sub_slot,
    input logic             tx_start,
    input logic [IDX_W-1:0] tx_slot,
    input logic [N_MB-1:0]  mb_empty,
    input logic [N_MB-1:0]  mb_fin,
    input logic [N_MB-1:0]  mb_ok,
    input logic             irq_en,
    input logic             irq
);
    AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_none) |=> !mb_empty[$past(sub_slot)]);                // R1
    AST_FIN_IMPLIES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_fin & ~mb_empty) == '0);                                             // R4
    AST_OK_IMPLIES_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_ok & ~mb_fin) == '0);                                                // R4
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);                                                 // R5
    AST_START_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !mb_empty[tx_slot]);                                        // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);                                                       // R11
endmodule

bind can_txmb_sched txmb_sva #(.N_MB(N_MB), .IDX_W(IDX_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_none(sub_none),
    .sub_slot(sub_slot), .tx_start(tx_start), .tx_slot(tx_slot),
    .mb_empty(mb_empty), .mb_fin(mb_fin), .mb_ok(mb_ok),
    .irq_en(irq_en), .irq(irq)
);

// File: tb/sim_can_txmb_sched.sv
// Bench: vector table of launch orders, then directed tests.
module sim_can_txmb_sched;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_valid = 1'b0;
    logic [31:0] sub_id = '0;
    logic [3:0]  sub_dlc = '0;
    logic [31:0] sub_data0 = '0, sub_data1 = '0;
    logic [1:0]  sub_slot;
    logic        sub_none;
    logic        cfg_fifo_order = 1'b0, cfg_no_retx = 1'b0, cfg_ttm = 1'b0, irq_en = 1'b0;
    logic [2:0]  stop_req = '0, clr_fin = '0;
    logic        tx_ready = 1'b0;
    logic        tx_start;
    logic [1:0]  tx_slot;
    logic [31:0] tx_id, tx_data0, tx_data1;
    logic [3:0]  tx_dlc;
    logic        tx_done = 1'b0, tx_lost = 1'b0, tx_err = 1'b0;
    logic [2:0]  mb_empty, mb_fin, mb_ok, mb_tse;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_txmb_sched u0 (.*);

    // Row: {id of mailbox 0, 1, 2, fifo mode, first, second, third launched mailbox}
    localparam logic [102:0] VEC [0:5] = '{
        {32'h2000_0000, 32'h0A00_0000, 32'h4000_0000, 1'b0, 2'd1, 2'd0, 2'd2},
        {32'h2460_0000, 32'h2460_0000, 32'h2460_0000, 1'b0, 2'd0, 2'd1, 2'd2},
        {32'hFFE0_0000, 32'h0020_0004, 32'h0020_0000, 1'b0, 2'd2, 2'd1, 2'd0},
        {32'h6000_0002, 32'h6000_0000, 32'h5FE0_0000, 1'b0, 2'd2, 2'd1, 2'd0},
        {32'h0200_002C, 32'h0200_001C, 32'h0220_0000, 1'b0, 2'd1, 2'd0, 2'd2},
        {32'h2000_0000, 32'h0A00_0000, 32'h4000_0000, 1'b1, 2'd0, 2'd1, 2'd2}
    };

    function automatic logic [31:0] pk(input int base);
        return {8'(base + 3), 8'(base + 2), 8'(base + 1), 8'(base)};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic submit(input logic [31:0] id, input int exp_slot);
        @(negedge clk);
        sub_valid = 1'b1; sub_id = id; sub_dlc = 4'd8;
        sub_data0 = pk(16 * exp_slot); sub_data1 = pk(16 * exp_slot + 4);
        #1;
        check("R1 alloc slot", {63'b0, sub_none}, 64'd0);
        check("R1 alloc slot", 64'(sub_slot), 64'(exp_slot));
        @(negedge clk);
        sub_valid = 1'b0;
    endtask

    // Wait for a launch, check it, answer with kind 0 done, 1 lost, 2 error.
    task automatic serve(input string tag, input int exp_slot, input logic [31:0] exp_id, input int kind);
        bit seen = 0;
        for (int t = 0; t < 40 && !seen; t++) begin
            @(negedge clk);
            if (tx_start) seen = 1;
        end
        check({tag, " launch seen"}, 64'(seen), 64'd1);
        check({tag, " launch slot"}, 64'(tx_slot), 64'(exp_slot));
        check({tag, " launch id"}, 64'(tx_id), 64'(exp_id | 32'd1));
        check("R5 data packing", {tx_data1, tx_data0}, {pk(16*exp_slot+4), pk(16*exp_slot)});
        check("R5 length code", 64'(tx_dlc), 64'd8);
        tx_done = (kind == 0); tx_lost = (kind == 1); tx_err = (kind == 2);
        @(negedge clk);
        tx_done = 1'b0; tx_lost = 1'b0; tx_err = 1'b0;
    endtask

    task automatic no_launch(input string tag);
        bit seen = 0;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            if (tx_start) seen = 1;
        end
        check(tag, 64'(seen), 64'd0);
    endtask

    task automatic status(input string tag, input int s, input logic [2:0] exp);
        check(tag, 64'({mb_empty[s], mb_fin[s], mb_ok[s]}), 64'(exp));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state
        check("R4 reset empty", 64'(mb_empty), 64'h7);
        check("R4 reset fin", 64'(mb_fin), 64'h0);
        check("R4 reset ok", 64'(mb_ok), 64'h0);
        check("R5 reset start", 64'(tx_start), 64'h0);
        check("R1 reset slot", 64'(sub_slot), 64'h0);
        irq_en = 1'b1;
        #1;
        check("R11 irq idle", 64'(irq), 64'h0);

        // Vector table: launch order under both policies
        for (int r = 0; r < 6; r++) begin
            tx_ready = 1'b0;
            cfg_fifo_order = VEC[r][6];
            for (int s = 0; s < 3; s++) submit(VEC[r][102-32*s -: 32], s);
            if (r == 0) begin
                @(negedge clk);
                sub_valid = 1'b1; sub_id = 32'h1234_5678;
                #1;
                check("R1 no mailbox", 64'(sub_none), 64'd1);
                @(negedge clk);
                sub_valid = 1'b0;
                check("R1 reject keeps mailboxes", 64'(mb_empty), 64'd0);
                status("R4 pending", 0, 3'b000);
            end
            @(negedge clk);
            tx_ready = 1'b1;
            for (int k = 0; k < 3; k++) begin
                int s;
                s = int'(VEC[r][5-2*k -: 2]);
                serve(VEC[r][6] ? "R3 order" : "R2 order", s, VEC[r][102-32*s -: 32], 0);
            end
            check("R6 all success", 64'({mb_empty, mb_fin, mb_ok}), 64'h1FF);
            if (r == 0) begin
                check("R11 irq on finish", 64'(irq), 64'd1);
                irq_en = 1'b0;
                #1;
                check("R11 irq masked", 64'(irq), 64'd0);
                irq_en = 1'b1;
            end
            clr_fin = 3'b111;
            @(negedge clk);
            clr_fin = 3'b000;
            check("R10 clear fin", 64'({mb_fin, mb_ok}), 64'h0);
            check("R11 irq after clear", 64'(irq), 64'd0);
        end

        // Request order after out-of-order freeing, plus abort of a pending mailbox
        tx_ready = 1'b0;
        cfg_fifo_order = 1'b1;
        submit(32'h2000_0000, 0);
        submit(32'h0A00_0000, 1);
        submit(32'h4000_0000, 2);
        @(negedge clk);
        stop_req = 3'b010;
        @(negedge clk);
        stop_req = 3'b000;
        status("R9 abort pending", 1, 3'b110);
        submit(32'h0020_0000, 1);
        @(negedge clk);
        tx_ready = 1'b1;
        serve("R3 age order", 0, 32'h2000_0000, 0);
        serve("R3 age order", 2, 32'h4000_0000, 0);
        serve("R3 age order", 1, 32'h0020_0000, 0);
        cfg_fifo_order = 1'b0;

        // Stop on a finished mailbox is ignored
        @(negedge clk);
        stop_req = 3'b001;
        @(negedge clk);
        stop_req = 3'b000;
        status("R9 stop finished ignored", 0, 3'b111);

        // Retry after lost arbitration
        submit(32'h1000_0000, 0);
        serve("R7 first attempt", 0, 32'h1000_0000, 1);
        status("R7 still pending", 0, 3'b000);
        serve("R7 retry", 0, 32'h1000_0000, 0);
        status("R6 success", 0, 3'b111);

        // No retransmission
        cfg_no_retx = 1'b1;
        submit(32'h1100_0000, 0);
        serve("R8 attempt", 0, 32'h1100_0000, 2);
        status("R8 failed", 0, 3'b110);
        no_launch("R8 no relaunch");
        cfg_no_retx = 1'b0;

        // Stop during flight then lost: failed without retry
        submit(32'h1200_0000, 0);
        begin
            bit seen = 0;
            for (int t = 0; t < 40 && !seen; t++) begin
                @(negedge clk);
                if (tx_start) seen = 1;
            end
            check("R9 inflight launch", 64'(seen), 64'd1);
        end
        stop_req = 3'b001;
        @(negedge clk);
        stop_req = 3'b000; tx_lost = 1'b1;
        @(negedge clk);
        tx_lost = 1'b0;
        status("R9 stop inflight lost", 0, 3'b110);
        no_launch("R9 no relaunch");

        // Stop during flight then done: success
        submit(32'h1300_0000, 0);
        begin
            bit seen = 0;
            for (int t = 0; t < 40 && !seen; t++) begin
                @(negedge clk);
                if (tx_start) seen = 1;
            end
            check("R9 inflight launch", 64'(seen), 64'd1);
        end
        stop_req = 3'b001;
        @(negedge clk);
        stop_req = 3'b000; tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        status("R9 stop inflight done", 0, 3'b111);

        // Time-stamp enables
        check("R12 tse off", 64'(mb_tse), 64'd0);
        cfg_ttm = 1'b1;
        @(negedge clk);
        check("R12 tse on", 64'(mb_tse), 64'h7);
        cfg_ttm = 1'b0;
        @(negedge clk);
        check("R12 tse off again", 64'(mb_tse), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule